// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block gives one node of a peer group a small 32-bit register window for signalling between nodes that share a memory region. Software on the node sees four registers: an interrupt mask, an interrupt status that clears itself when it is read, a read-only node identifier, and a write-only doorbell. A write to the doorbell is split into a target peer identifier (upper half-word) and a vector number (lower half-word). That pair leaves the block as an outgoing event on a valid/ready port, and the transport between nodes carries it to the peer.

Events addressed to this node arrive on a second port. An arriving event whose peer field equals this node's identifier, and whose vector is below the configured vector count, sets that vector's pending flag. The flag stays set until a per-vector acknowledge input clears it. A level interrupt line is raised while any status bit is also enabled in the mask.

The register port is a request with valid/ready. Reads return one cycle after acceptance. The only back-pressure on the register port comes from the outgoing event slot. A doorbell write is held off while an earlier event is still waiting for the transport. Every other access is accepted at once. The incoming event port is always ready.

Top module: `shmdb_top`

## Requirements
- R1: After reset the mask, status and identifier registers (with node identifier input 0) read zero, `irq` is low, all pending flags are clear and no outgoing event is valid.
- R2: The mask register (byte offset 0) stores any 32-bit write, for example 0xFFFFFFFF, and reads it back unchanged.
- R3: A write to the status register (byte offset 4) replaces its contents with the written value. The first read afterwards returns that value and clears the register, so the next read returns zero.
- R4: The identifier register (byte offset 8) always reads the `node_id` input, zero-extended. Writes to it change no register and no output.
- R5: A read of the doorbell (byte offset 12) returns zero with `rd_err` high for that response. A read of any other offset in the 256-byte window returns zero with `rd_err` low. The offset is decoded from `reg_addr[7:2]`.
- R6: An accepted doorbell write raises `ev_out_valid` on the next cycle, with `ev_out_peer` = write data bits 31:16 and `ev_out_vec` = bits 15:0. These are held unchanged until a cycle with `ev_out_ready` high, after which valid drops unless a new doorbell was accepted.
- R7: While an outgoing event is waiting, `reg_ready` is low for a doorbell write request and high for every other request, so no doorbell is lost.
- R8: `irq` is high exactly when the bitwise AND of status and mask is nonzero.
- R9: An incoming event sets `pending[v]` on the next cycle only if `ev_in_peer` equals `node_id` and `ev_in_vec` = v < NVEC. Other events change no flag, and `ev_in_ready` is always high.
- R10: A pending flag stays set until its `pend_ack` bit is high. When a set and an acknowledge of the same vector meet in one cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Register request accepted this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset in the register window |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid (one cycle after acceptance) |
| rd_data | output | 32 | Read response data |
| rd_err | output | 1 | Read response flags an invalid read |
| node_id | input | 16 | Identifier assigned to this node |
| irq | output | 1 | Level interrupt, status AND mask nonzero |
| ev_out_valid | output | 1 | Outgoing doorbell event valid |
| ev_out_ready | input | 1 | Transport accepts the outgoing event |
| ev_out_peer | output | 16 | Target peer of the outgoing event |
| ev_out_vec | output | 16 | Vector field of the outgoing event |
| ev_in_valid | input | 1 | Incoming event valid |
| ev_in_ready | output | 1 | Incoming event accepted (always high) |
| ev_in_peer | input | 16 | Peer the incoming event is addressed to |
| ev_in_vec | input | 16 | Vector of the incoming event |
| pend_ack | input | NVEC | Per-vector pending flag clear |
| pending | output | NVEC | Per-vector pending flags |

## Verification
The assertions assume that a requester whose request is stalled keeps `reg_valid`, `reg_we`, `reg_addr` and `reg_wdata` stable until `reg_ready` is seen high. They also assume that `ev_out_ready` is driven to a known level every cycle. The random phase of the stimulus samples `reg_ready` in mid-cycle and repeats a stalled request unchanged until it is accepted, and draws `ev_out_ready` freshly on each cycle. Incoming events, acknowledges, node identifier changes and out-of-range vectors are drawn with no such restriction, because the block must tolerate any pattern on those pins.

// File: rtl/shmdb_pkg.sv
package shmdb_pkg;
  // Word index within the register window (byte offset / 4).
  typedef enum logic [5:0] {
    W_MASK = 6'd0,
    W_STAT = 6'd1,
    W_NODE = 6'd2,
    W_BELL = 6'd3
  } reg_word_e;

  localparam int unsigned WORD_BITS = 6;
  localparam int unsigned ADDR_BITS = WORD_BITS + 2;
endpackage

// File: rtl/shmdb_regfile.sv
module shmdb_regfile
  import shmdb_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned PW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  logic                 we,
  input  logic [WORD_BITS-1:0] word,
  input  logic [DW-1:0]        wdata,
  input  logic [PW-1:0]        node_id,
  output logic [DW-1:0]        mask_q,
  output logic [DW-1:0]        status_q,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_err
);
  logic          rd_acc;
  logic          wr_acc;
  logic [DW-1:0] rmux;

  assign rd_acc = acc && !we;
  assign wr_acc = acc && we;

  always_comb begin
    rmux = '0;
    case (word)
      W_MASK:  rmux = mask_q;
      W_STAT:  rmux = status_q;
      W_NODE:  rmux = DW'(node_id);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      rd_err   <= rd_acc && (word == W_BELL);
      if (rd_acc) rd_data <= rmux;
      if (wr_acc && word == W_MASK) mask_q <= wdata;
      if (wr_acc && word == W_STAT) status_q <= wdata;
      if (rd_acc && word == W_STAT) status_q <= '0;
    end
  end

  p_mask_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && word == W_MASK) |=> (mask_q == $past(wdata)));

  p_rdclr_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && word == W_STAT) |=> (status_q == '0 && rd_data == $past(status_q)));

  p_bellerr_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_valid && rd_data == '0));
endmodule

// File: rtl/shmdb_out_slot.sv
module shmdb_out_slot #(
  parameter int unsigned PW = 16,
  parameter int unsigned VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_peer,
  input  logic [VW-1:0] load_vec,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_peer,
  output logic [VW-1:0] out_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_peer  <= '0;
      out_vec   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_peer  <= load_peer;
      out_vec   <= load_vec;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign full = out_valid;

  p_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_peer) && $stable(out_vec)));

  p_noclobber_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/shmdb_pending.sv
module shmdb_pending #(
  parameter int unsigned NVEC = 2,
  parameter int unsigned PW   = 16,
  parameter int unsigned VW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  logic [PW-1:0]   ev_peer,
  input  logic [VW-1:0]   ev_vec,
  input  logic [PW-1:0]   node_id,
  input  logic [NVEC-1:0] ack,
  output logic [NVEC-1:0] pend
);
  logic to_me;
  assign to_me = ev_valid && (ev_peer == node_id);

  for (genvar i = 0; i < NVEC; i++) begin : g_vec
    logic hit;
    assign hit = to_me && (ev_vec == VW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= hit | (pend[i] & ~ack[i]);
    end
  end

  p_drop_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_peer == node_id && ev_vec < VW'(NVEC))
      |=> ((pend & ~$past(pend)) == '0));

  p_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~$past(ack)) & ~pend) == '0));
endmodule

// File: rtl/shmdb_top.sv
module shmdb_top
  import shmdb_pkg::*;
#(
  parameter int unsigned NVEC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_valid,
  output logic            reg_ready,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic            rd_valid,
  output logic [31:0]     rd_data,
  output logic            rd_err,
  input  logic [15:0]     node_id,
  output logic            irq,
  output logic            ev_out_valid,
  input  logic            ev_out_ready,
  output logic [15:0]     ev_out_peer,
  output logic [15:0]     ev_out_vec,
  input  logic            ev_in_valid,
  output logic            ev_in_ready,
  input  logic [15:0]     ev_in_peer,
  input  logic [15:0]     ev_in_vec,
  input  logic [NVEC-1:0] pend_ack,
  output logic [NVEC-1:0] pending
);
  localparam int unsigned DW = 32;
  localparam int unsigned PW = DW / 2;
  localparam int unsigned VW = DW - PW;

  logic [WORD_BITS-1:0] word;
  logic                 unused_lsb;
  logic                 slot_full;
  logic                 is_bell_wr;
  logic                 acc;
  logic [DW-1:0]        mask_q;
  logic [DW-1:0]        status_q;

  assign word       = reg_addr[ADDR_BITS-1:2];
  assign unused_lsb = ^reg_addr[1:0];
  assign is_bell_wr = reg_valid && reg_we && (word == W_BELL);
  assign reg_ready  = !(is_bell_wr && slot_full);
  assign acc        = reg_valid && reg_ready;
  assign irq        = |(mask_q & status_q);
  assign ev_in_ready = 1'b1;

  shmdb_regfile #(.DW(DW), .PW(PW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .we       (reg_we),
    .word     (word),
    .wdata    (reg_wdata),
    .node_id  (node_id),
    .mask_q   (mask_q),
    .status_q (status_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_err   (rd_err)
  );

  shmdb_out_slot #(.PW(PW), .VW(VW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc && is_bell_wr),
    .load_peer (reg_wdata[DW-1:VW]),
    .load_vec  (reg_wdata[VW-1:0]),
    .full      (slot_full),
    .out_valid (ev_out_valid),
    .out_ready (ev_out_ready),
    .out_peer  (ev_out_peer),
    .out_vec   (ev_out_vec)
  );

  shmdb_pending #(.NVEC(NVEC), .PW(PW), .VW(VW)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_in_valid),
    .ev_peer  (ev_in_peer),
    .ev_vec   (ev_in_vec),
    .node_id  (node_id),
    .ack      (pend_ack),
    .pend     (pending)
  );

  p_stall_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    !reg_ready |-> (reg_valid && reg_we && word == W_BELL && ev_out_valid));

  p_irq_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (irq == 1'b0) |-> ((mask_q & status_q) == '0));

  p_bell_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_bell_wr) |=> (ev_out_valid && ev_out_peer == $past(reg_wdata[31:16])
                             && ev_out_vec == $past(reg_wdata[15:0])));
endmodule

// File: tb/shmdb_top_tb.sv
module shmdb_top_tb;
  localparam int NV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [15:0] node_id = '0;
  logic ev_out_ready = 1'b1;
  logic ev_in_valid = 1'b0;
  logic [15:0] ev_in_peer = '0, ev_in_vec = '0;
  logic [NV-1:0] pend_ack = '0;
  logic reg_ready, rd_valid, rd_err, irq, ev_out_valid, ev_in_ready;
  logic [31:0] rd_data;
  logic [15:0] ev_out_peer, ev_out_vec;
  logic [NV-1:0] pending;

  always #2 clk = ~clk;

  shmdb_top #(.NVEC(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err), .node_id(node_id),
    .irq(irq), .ev_out_valid(ev_out_valid), .ev_out_ready(ev_out_ready),
    .ev_out_peer(ev_out_peer), .ev_out_vec(ev_out_vec), .ev_in_valid(ev_in_valid),
    .ev_in_ready(ev_in_ready), .ev_in_peer(ev_in_peer), .ev_in_vec(ev_in_vec),
    .pend_ack(pend_ack), .pending(pending)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference model
  logic [31:0] m_mask, m_stat, m_rdata;
  logic        m_rv, m_err;
  logic [NV-1:0] m_pend;
  logic [31:0] m_q[$];
  string       m_tag;

  function automatic bit m_ready();
    return !(reg_valid && reg_we && reg_addr[7:2] == 6'd3 && m_q.size() != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_stat = 0; m_rv = 0; m_err = 0; m_rdata = 0; m_pend = 0;
      m_q.delete(); m_tag = "R1";
    end else begin
      bit acc;
      logic [NV-1:0] set;
      acc = reg_valid && m_ready();
      if (m_q.size() != 0 && ev_out_ready) void'(m_q.pop_front());
      m_rv = acc && !reg_we;
      m_err = 0;
      if (acc && !reg_we) begin
        case (int'(reg_addr[7:2]))
          0: begin m_rdata = m_mask; m_tag = "R2"; end
          1: begin m_rdata = m_stat; m_stat = 0; m_tag = "R3"; end
          2: begin m_rdata = {16'h0, node_id}; m_tag = "R4"; end
          3: begin m_rdata = 0; m_err = 1; m_tag = "R5"; end
          default: begin m_rdata = 0; m_tag = "R5"; end
        endcase
      end
      if (acc && reg_we) begin
        case (int'(reg_addr[7:2]))
          0: m_mask = reg_wdata;
          1: m_stat = reg_wdata;
          3: m_q.push_back(reg_wdata);
          default: ;
        endcase
      end
      set = '0;
      for (int v = 0; v < NV; v++)
        if (ev_in_valid && ev_in_peer == node_id && int'(ev_in_vec) == v) set[v] = 1'b1;
      m_pend = (m_pend & ~pend_ack) | set;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle, mid-cycle after stimulus has settled
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R7 reg_ready", {31'h0, reg_ready}, {31'h0, m_ready()});
      chk("R5 rd_valid", {31'h0, rd_valid}, {31'h0, m_rv});
      chk("R5 rd_err", {31'h0, rd_err}, {31'h0, m_err});
      if (m_rv) chk({m_tag, " rd_data"}, rd_data, m_rdata);
      chk("R8 irq", {31'h0, irq}, {31'h0, |(m_mask & m_stat)});
      chk("R6 ev_out_valid", {31'h0, ev_out_valid}, {31'h0, m_q.size() != 0});
      if (m_q.size() != 0) chk("R6 ev_out fields", {ev_out_peer, ev_out_vec}, m_q[0]);
      chk("R9 R10 pending", 32'(pending), 32'(m_pend));
      chk("R9 ev_in_ready", {31'h0, ev_in_ready}, 32'h1);
    end
  end

  // Directed register access, holding the request until accepted
  task automatic reg_op(bit we, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_we = we; reg_addr = a; reg_wdata = d;
    #1;
    while (!reg_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic in_ev(logic [15:0] p, logic [15:0] v, logic [NV-1:0] a);
    @(negedge clk);
    ev_in_valid = 1; ev_in_peer = p; ev_in_vec = v; pend_ack = a;
    @(negedge clk);
    ev_in_valid = 0; pend_ack = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit stalled;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state at the ports
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 pending", 32'(pending), 0);
    chk("R1 ev_out_valid", {31'h0, ev_out_valid}, 0);
    reg_op(0, 8'd0, 0); reg_op(0, 8'd4, 0); reg_op(0, 8'd8, 0);
    // R2 mask, R3 status clear-on-read, R8 irq
    reg_op(1, 8'd0, 32'hFFFF_FFFF); reg_op(0, 8'd0, 0);
    reg_op(1, 8'd4, 32'h1);
    reg_op(0, 8'd4, 0); reg_op(0, 8'd4, 0);
    reg_op(1, 8'd0, 32'h0000_0F00); reg_op(1, 8'd4, 32'h0000_0100);
    reg_op(1, 8'd4, 32'h0000_00FF); reg_op(0, 8'd4, 0);
    // R4 identifier ignores writes
    node_id = 16'h0007;
    reg_op(1, 8'd8, 32'h1); reg_op(0, 8'd8, 0);
    reg_op(0, 8'd0, 0);
    // R5 doorbell read and unmapped offsets
    reg_op(0, 8'd12, 0); reg_op(0, 8'h40, 0); reg_op(0, 8'hFC, 0);
    // R6 R7 doorbell with back-pressure
    ev_out_ready = 0;
    reg_op(1, 8'd12, {16'h0003, 16'h0001});
    fork
      reg_op(1, 8'd12, {16'h0004, 16'h0000});
      begin repeat (5) @(negedge clk); ev_out_ready = 1; end
    join
    repeat (3) @(negedge clk);
    // R9 R10 incoming events
    in_ev(16'h0007, 16'd0, '0);
    in_ev(16'h0007, 16'd1, '0);
    in_ev(16'h0007, 16'd2, '0);
    in_ev(16'h0008, 16'd0, 2'b11);
    in_ev(16'h0007, 16'd1, 2'b10);
    in_ev(16'h0001, 16'd5, 2'b11);
    // Random phase
    stalled = 0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (!stalled) begin
        reg_valid = ($urandom_range(0, 2) != 0);
        reg_we = $urandom_range(0, 1);
        case ($urandom_range(0, 5))
          0: reg_addr = 8'd0; 1: reg_addr = 8'd4; 2: reg_addr = 8'd8;
          3, 4: reg_addr = 8'd12; default: reg_addr = 8'(4 * $urandom_range(4, 63));
        endcase
        reg_wdata = $urandom;
        if ($urandom_range(0, 1) != 0) reg_wdata[31:16] = 16'h0;
      end
      ev_out_ready = ($urandom_range(0, 3) != 0);
      ev_in_valid = $urandom_range(0, 1);
      ev_in_peer = ($urandom_range(0, 2) != 0) ? node_id : 16'(n);
      ev_in_vec = 16'($urandom_range(0, 3));
      pend_ack = NV'($urandom_range(0, 3));
      if (n % 1000 == 999) node_id = 16'($urandom_range(0, 9));
      #1;
      stalled = reg_valid && !reg_ready;
    end
    @(negedge clk);
    reg_valid = 0; ev_in_valid = 0;
    repeat (4) @(negedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule